// File: doc/BRIEF.md
# Tree-Walk Reconfiguration Sequencer

This block drives the switch-enable bits of a spare-rich linear array so that, one time-out at a time, every embedded path of the array is tried in turn until a working one is found. A one-hot root register picks the head block of the current search tree. Every block whose tail fans out to two successors owns a small cyclic selector that chooses one of its two outgoing edges. Blocks with a single outgoing edge simply pass their activity on. The enables of the array's external connections are the activity of each block, that is, the OR of its enabled incoming edges, or the root bit for a head block.

The search is hierarchical. A selector keeps its choice while any selector below it still has alternatives left. The deepest unfinished selector advances on each time-out. The root register moves on only after every selector on the active path has used its last choice. A time-out is taken as the rising edge of `timeout_i`. All state lives in one clock domain, and new selections settle through a few cycles of rise detection after each time-out.

The default topology is a fixed example with three roots, seven blocks and eight internal edges. It is described in R11.

Top module: `twalk_seq`

## Requirements
- R1: While reset is asserted, and after reset until the first time-out, `root_o`, `int_cfg_o` and `ext_cfg_o` are all zero.
- R2: A rising edge of `timeout_i` that finds the current tree fully searched moves the single set bit of `root_o` one position up. The first such edge after reset sets bit 0. With `timeout_i` held low, nothing changes.
- R3: The root stays put on a time-out while any fork on the active path still sits on its first choice.
- R4: A block with one outgoing edge enables that edge exactly when the block is active. This holds for a merge block with two incoming edges and for a head block.
- R5: A fork enables neither outgoing edge while inactive. One cycle after it becomes active, it enables its first edge. It never enables both edges at once.
- R6: A time-out steps a fork from its first edge to its second only when no fork below it is on a first choice. A parent fork therefore holds while its descendants finish.
- R7: A fork with two incoming edges is started by either of them. The same fork is walked afresh under each root that reaches it.
- R8: Bit k of `ext_cfg_o` is 1 exactly when block k is active, meaning the root bit for a head block or any enabled incoming edge.
- R9: After the last root's tree is exhausted, the next time-out returns to root 0, and the search repeats without end.
- R10: A time-out level held high for several cycles acts as a single time-out.
- R11: Default topology, with edge k at bit k of `int_cfg_o` and block k at bit k of `ext_cfg_o`. Edges: 0: B0→B2, 1: B0→B3, 2: B1→B3, 3: B2→B4, 4: B2→B5, 5: B3→B5, 6: B3→B6, 7: B5→B6. Roots 0, 1 and 2 head B0, B1 and B5. Forks are B0, B2 and B3, each with its lower-numbered edge first. The visiting order is 0x09, 0x91, 0xA2, 0x42 (root 0), then 0xA4, 0x44 (root 1), then 0x80 (root 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timeout_i | input | 1 | Deadlock time-out level; its rising edge is one search step |
| root_o | output | NUM_ROOTS | One-hot current head block of the search tree |
| int_cfg_o | output | NUM_EDGES | Internal edge enables |
| ext_cfg_o | output | NUM_BLOCKS | External connection enable per block |

## Verification
The bench walks three full rounds of the seven configurations and compares every output after each time-out. This exposes a fork that steps while a child is unfinished, which would skip the left subtree. It also exposes a root that advances mid-tree, which would drop paths. The two-input fork B3 is entered from root 0 and then from root 1, so a design that fails to restart it when its enabling edge changes would stay on its second choice and miss configuration 0xA4. Long time-out pulses check that a level-sensitive design, which would skip several configurations, is caught. The wrap from root 2 back to root 0 is checked over two rounds.

// File: rtl/twalk_pkg.sv
package twalk_pkg;

  localparam int NR  = 3;
  localparam int NE  = 8;
  localparam int NB  = 7;
  localparam int NBR = 3;

  localparam int EIW = (NE  > 1) ? $clog2(NE)  : 1;
  localparam int BIW = (NB  > 1) ? $clog2(NB)  : 1;
  localparam int FIW = (NBR > 1) ? $clog2(NBR) : 1;

  typedef enum logic [1:0] {
    SEL_IDLE = 2'b00,
    SEL_A    = 2'b01,
    SEL_B    = 2'b10
  } sel_e;

  localparam int KIND_TAIL = 0;
  localparam int KIND_PASS = 1;
  localparam int KIND_FORK = 2;

  // Blocks are listed in topological order: every edge goes to a higher index.
  localparam int BLK_KIND [NB] = '{KIND_FORK, KIND_PASS, KIND_FORK, KIND_FORK,
                                   KIND_TAIL, KIND_PASS, KIND_TAIL};
  localparam logic [NE-1:0] BLK_IN [NB] = '{8'h00, 8'h00, 8'h01, 8'h06,
                                            8'h08, 8'h30, 8'hC0};
  localparam logic [NR-1:0] BLK_ROOT [NB] = '{3'b001, 3'b010, 3'b000, 3'b000,
                                              3'b000, 3'b100, 3'b000};
  localparam logic [EIW-1:0] BLK_OUT0 [NB] = '{3'd0, 3'd2, 3'd3, 3'd5,
                                               3'd0, 3'd7, 3'd0};
  localparam logic [EIW-1:0] BLK_OUT1 [NB] = '{3'd1, 3'd0, 3'd4, 3'd6,
                                               3'd0, 3'd0, 3'd0};
  localparam logic [FIW-1:0] BLK_FORK [NB] = '{2'd0, 2'd0, 2'd1, 2'd2,
                                               2'd0, 2'd0, 2'd0};
  localparam int FORK_BLK [NBR] = '{0, 2, 3};
  // Forks reachable below each fork (bit d set: fork d is a descendant).
  localparam logic [NBR-1:0] FORK_DESC [NBR] = '{3'b110, 3'b000, 3'b000};

endpackage

// File: rtl/twalk_rise.sv
module twalk_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic pulse_o
);

  logic lvl_q;
  logic lvl_d;

  always_comb begin
    lvl_d = lvl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
    end
  end

  assign pulse_o = lvl_i & ~lvl_q;

endmodule

// File: rtl/twalk_root_ring.sv
module twalk_root_ring #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv_i,
  output logic [N-1:0] hot_o
);

  logic [N-1:0] hot_q;
  logic [N-1:0] hot_d;

  generate
    if (N == 1) begin : g_single
      always_comb begin
        hot_d = hot_q;
        if (adv_i) hot_d = 1'b1;
      end
    end else begin : g_ring
      always_comb begin
        hot_d = hot_q;
        if (adv_i) begin
          if (hot_q == '0) hot_d = {{(N-1){1'b0}}, 1'b1};
          else             hot_d = {hot_q[N-2:0], hot_q[N-1]};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hot_q <= '0;
    end else begin
      hot_q <= hot_d;
    end
  end

  assign hot_o = hot_q;

endmodule

// File: rtl/twalk_fork_ctr.sv
module twalk_fork_ctr
  import twalk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic act_i,
  input  logic step_i,
  output sel_e sel_o
);

  sel_e sel_q;
  sel_e sel_d;
  logic act_q;
  logic act_d;

  always_comb begin
    sel_d = sel_q;
    act_d = act_i;
    if (restart_i) begin
      sel_d = SEL_IDLE;
      act_d = 1'b0;
    end else if (!act_i) begin
      sel_d = SEL_IDLE;
    end else if (!act_q) begin
      sel_d = SEL_A;
    end else if (step_i && (sel_q == SEL_A)) begin
      sel_d = SEL_B;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SEL_IDLE;
      act_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      act_q <= act_d;
    end
  end

  assign sel_o = sel_q;

endmodule

// File: rtl/twalk_seq.sv
module twalk_seq
  import twalk_pkg::*;
#(
  parameter int NUM_ROOTS  = twalk_pkg::NR,
  parameter int NUM_EDGES  = twalk_pkg::NE,
  parameter int NUM_BLOCKS = twalk_pkg::NB,
  parameter int NUM_FORKS  = twalk_pkg::NBR
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  timeout_i,
  output logic [NUM_ROOTS-1:0]  root_o,
  output logic [NUM_EDGES-1:0]  int_cfg_o,
  output logic [NUM_BLOCKS-1:0] ext_cfg_o
);

  localparam int LBIW = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;
  localparam int LFIW = (NUM_FORKS  > 1) ? $clog2(NUM_FORKS)  : 1;

  logic                  tick;
  logic                  walk_done;
  logic                  restart;
  logic [NUM_ROOTS-1:0]  root_q;
  logic [NUM_EDGES-1:0]  edge_v;
  logic [NUM_BLOCKS-1:0] blk_act;
  logic [NUM_FORKS-1:0]  desc_ok;
  sel_e                  fork_sel [NUM_FORKS];

  twalk_rise u_rise (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl_i   (timeout_i),
    .pulse_o (tick)
  );

  always_comb begin
    walk_done = 1'b1;
    for (int k = 0; k < NUM_FORKS; k++) begin
      if (fork_sel[k[LFIW-1:0]] == SEL_A) walk_done = 1'b0;
    end
  end

  assign restart = tick & walk_done;

  twalk_root_ring #(.N(NUM_ROOTS)) u_ring (
    .clk   (clk),
    .rst_n (rst_n),
    .adv_i (restart),
    .hot_o (root_q)
  );

  // A fork may step only when none of its descendants is still on a first choice.
  always_comb begin
    for (int k = 0; k < NUM_FORKS; k++) begin
      desc_ok[k[LFIW-1:0]] = 1'b1;
      for (int d = 0; d < NUM_FORKS; d++) begin
        if (FORK_DESC[k[LFIW-1:0]][d[LFIW-1:0]] && (fork_sel[d[LFIW-1:0]] == SEL_A))
          desc_ok[k[LFIW-1:0]] = 1'b0;
      end
    end
  end

  generate
    for (genvar k = 0; k < NUM_FORKS; k++) begin : g_fork
      twalk_fork_ctr u_fork (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .act_i     (blk_act[FORK_BLK[k]]),
        .step_i    (tick & desc_ok[k]),
        .sel_o     (fork_sel[k])
      );
    end
  endgenerate

  // Enables are resolved block by block in topological order.
  always_comb begin
    edge_v  = '0;
    blk_act = '0;
    for (int b = 0; b < NUM_BLOCKS; b++) begin
      blk_act[b[LBIW-1:0]] = (|(edge_v & BLK_IN[b[LBIW-1:0]]))
                           | (|(root_q & BLK_ROOT[b[LBIW-1:0]]));
      if (BLK_KIND[b[LBIW-1:0]] == KIND_FORK) begin
        edge_v[BLK_OUT0[b[LBIW-1:0]]] = blk_act[b[LBIW-1:0]]
          & (fork_sel[BLK_FORK[b[LBIW-1:0]]] == SEL_A);
        edge_v[BLK_OUT1[b[LBIW-1:0]]] = blk_act[b[LBIW-1:0]]
          & (fork_sel[BLK_FORK[b[LBIW-1:0]]] == SEL_B);
      end else if (BLK_KIND[b[LBIW-1:0]] == KIND_PASS) begin
        edge_v[BLK_OUT0[b[LBIW-1:0]]] = blk_act[b[LBIW-1:0]];
      end
    end
  end

  assign root_o    = root_q;
  assign int_cfg_o = edge_v;
  assign ext_cfg_o = blk_act;

endmodule

// File: rtl/twalk_seq_chk.sv
module twalk_seq_chk
  import twalk_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic [NR-1:0] root,
  input logic [NE-1:0] int_cfg,
  input logic [NB-1:0] ext_cfg
);

  function automatic logic [NE-1:0] first_choice_mask();
    logic [NE-1:0] m;
    m = '0;
    for (int b = 0; b < NB; b++) begin
      if (BLK_KIND[b[BIW-1:0]] == KIND_FORK) m[BLK_OUT0[b[BIW-1:0]]] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [NE-1:0] A_MASK = first_choice_mask();

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (root == '0 && int_cfg == '0 && ext_cfg == '0));

  p_root_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(root));

  p_root_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(root));

  p_root_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (root != $past(root)) |-> (($past(int_cfg) & A_MASK) == '0));

  generate
    for (genvar b = 0; b < NB; b++) begin : g_blk
      if (BLK_KIND[b] == KIND_FORK) begin : g_fork
        p_fork_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
          $onehot0({int_cfg[BLK_OUT0[b]], int_cfg[BLK_OUT1[b]]}));

        p_fork_needs_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
          (int_cfg[BLK_OUT0[b]] | int_cfg[BLK_OUT1[b]]) |-> ext_cfg[b]);

        p_fork_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
          ($rose(ext_cfg[b]) && !tick) |=> int_cfg[BLK_OUT0[b]]);
      end
    end
  endgenerate

endmodule

bind twalk_seq twalk_seq_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick),
  .root    (root_o),
  .int_cfg (int_cfg_o),
  .ext_cfg (ext_cfg_o)
);

// File: tb/twalk_seq_test.sv
module twalk_seq_test;

  logic       clk;
  logic       rst_n;
  logic       timeout_i;
  logic [2:0] root_o;
  logic [7:0] int_cfg_o;
  logic [6:0] ext_cfg_o;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 0;

  twalk_seq uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .timeout_i (timeout_i),
    .root_o    (root_o),
    .int_cfg_o (int_cfg_o),
    .ext_cfg_o (ext_cfg_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Visiting order of the example topology (R11).
  function automatic logic [7:0] exp_int(int s);
    case (s % 7)
      0:       return 8'h09;
      1:       return 8'h91;
      2:       return 8'hA2;
      3:       return 8'h42;
      4:       return 8'hA4;
      5:       return 8'h44;
      default: return 8'h80;
    endcase
  endfunction

  function automatic logic [2:0] exp_root(int s);
    if ((s % 7) < 4)      return 3'b001;
    else if ((s % 7) < 6) return 3'b010;
    else                  return 3'b100;
  endfunction

  // Block activity from root bits and edges (R8).
  function automatic logic [6:0] exp_ext(logic [2:0] r, logic [7:0] e);
    logic [6:0] x;
    x[0] = r[0];
    x[1] = r[1];
    x[2] = e[0];
    x[3] = e[1] | e[2];
    x[4] = e[3];
    x[5] = e[4] | e[5] | r[2];
    x[6] = e[6] | e[7];
    return x;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse(int len);
    @(negedge clk);
    timeout_i = 1'b1;
    repeat (len) @(negedge clk);
    timeout_i = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    timeout_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 root in reset", {5'b0, root_o}, 8'h00);
    check("R1 int in reset", int_cfg_o, 8'h00);
    check("R1 ext in reset", {1'b0, ext_cfg_o}, 8'h00);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R1 root idle", {5'b0, root_o}, 8'h00);
    check("R2 int without timeout", int_cfg_o, 8'h00);
    check("R1 ext idle", {1'b0, ext_cfg_o}, 8'h00);

    for (int s = 0; s < 21; s++) begin
      logic [2:0] er;
      logic [7:0] ei;
      string      rtag;
      string      itag;
      bit         longp;
      longp = (s == 4) || (s == 9) || (s == 16);
      pulse(longp ? 6 : 1);
      er = exp_root(s);
      ei = exp_int(s);
      if (s >= 7 && (s % 7) == 0)      rtag = "R9 wrap root";
      else if ((s % 7) == 0 || (s % 7) == 4 || (s % 7) == 6) rtag = "R2 root step";
      else                             rtag = "R3 root frozen";
      case (s % 7)
        0:       itag = "R5 R11 first choices";
        1:       itag = "R6 R4 child steps";
        2:       itag = "R6 parent steps";
        3:       itag = "R7 fork via edge1";
        4:       itag = "R7 fork via edge2";
        5:       itag = "R6 R11 second root";
        default: itag = "R4 head merge block";
      endcase
      if (longp) begin
        rtag = {"R10 ", rtag};
        itag = {"R10 ", itag};
      end
      check($sformatf("%s step %0d", rtag, s), {5'b0, root_o}, {5'b0, er});
      check($sformatf("%s step %0d", itag, s), int_cfg_o, ei);
      check($sformatf("R8 ext step %0d", s), {1'b0, ext_cfg_o},
            {1'b0, exp_ext(er, ei)});
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule